// File: doc/BRIEF.md
# Double-Sampling Timing Error Register

This block is a pipeline register that takes two samples of the same data input. A main register captures the input on the rising edge of the main clock. A shadow register captures it again on the rising edge of a second clock, which runs at the same frequency but is shifted later by a fixed offset. Data that settles after the main edge but before the delayed edge is therefore held correctly only in the shadow register. A bitwise comparison of the two samples detects this case.

A mismatch is handled as a timing error, and the shadow copy is taken as the correct value. On the next main edge the main register is reloaded from the shadow register. A registered error flag and a stall request are raised for one cycle, and a saturating counter records the event. Upstream logic must hold its data while the stall is high, so that the corrected value has one extra cycle to propagate.

The correction is only sound for late arrival. If a particle strike corrupts either copy, the flag still reports the mismatch, but the restored value may be the wrong one. Every path into the input must also be slower than the clock offset. Otherwise the shadow register captures data meant for the next cycle.

Top module: `dsamp_reg`

## Requirements
- R1: While reset is low at a main clock edge (synchronous, active low), `q`, `err_flag`, `stall` and `err_cnt` are all zero on the following cycle.
- R2: If the input is stable before the main edge and until after the delayed edge, then `q` shows that input after the main edge, and `err_flag` and `stall` stay 0 on the next edge.
- R3: If the input changes after a main edge but before the following delayed edge, `err_flag` is 1 for exactly the one cycle after the next main edge.
- R4: On the main edge that raises `err_flag`, `q` is loaded with the shadow sample (the late value), not with the current input.
- R5: `stall` is 1 in exactly the same cycles as `err_flag` and is never 1 in two consecutive cycles.
- R6: During a stall cycle the comparison is ignored. A disagreement between the samples in that cycle raises neither `err_flag` nor `stall` on the next edge.
- R7: `err_cnt` increases by exactly one on each edge that raises `err_flag` and is otherwise unchanged.
- R8: `err_cnt` saturates at 2^CNT_W-1 and stays there on further errors.
- R9: A mismatch in any single bit, including the most significant bit, is flagged.
- R10: Checking resumes immediately after a stall. Late data in the cycle after a stall is flagged and corrected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main sampling clock |
| clk_dly | input | 1 | Same clock delayed by a fixed offset, used for the shadow sample |
| rst_n | input | 1 | Synchronous active-low reset |
| d | input | WIDTH | Data from the combinational stage |
| q | output | WIDTH | Registered (and, after an error, corrected) data |
| err_flag | output | 1 | One-cycle flag: a mismatch was found and corrected |
| stall | output | 1 | One-cycle pipeline stall request |
| err_cnt | output | CNT_W | Saturating count of flagged mismatches |

## Verification
A stuck or wrong shadow sample shows up on `q` within one main cycle after a late transition, because the corrected value is visible right after the next edge. A fault in the masking logic appears either as a second consecutive `stall` or as a missing flag on the cycle right after a stall. Both are visible at the ports two edges after the stimulus. A counter fault shows in `err_cnt` on the same edge as the flag, and saturation faults show after the sixteenth error.

// File: rtl/dsamp_pkg.sv
// Shared types for the double-sampling register.
// Assumes nothing beyond standard packed types.
package dsamp_pkg;

    // Registered outcome of one comparison window.
    typedef struct packed {
        logic flag;
        logic stall;
    } dsamp_event_s;

endpackage

// File: rtl/dsamp_shadow_stage.sv
// Shadow sampling register clocked by the delayed clock.
// Assumes clk_dly has the main clock frequency and a fixed, positive
// offset smaller than half a period, and that rst_n is held across
// at least one delayed edge.
module dsamp_shadow_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk_dly,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q_shd
);

    // Capture the late-arriving data on the delayed edge.
    always_ff @(posedge clk_dly) begin
        if (!rst_n) begin
            q_shd <= '0;
        end else begin
            q_shd <= d;
        end
    end

endmodule

// File: rtl/dsamp_main_stage.sv
// Main pipeline register with a reload path from the shadow sample.
// Assumes load_shadow is computed from values stable at the main edge.
module dsamp_main_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    input  logic             load_shadow,
    input  logic [WIDTH-1:0] shadow_q,
    output logic [WIDTH-1:0] q_main
);

    logic [WIDTH-1:0] next_val;

    // Choose the corrected value when an error is being repaired.
    always_comb begin
        next_val = load_shadow ? shadow_q : d;
    end

    // Main register update on the main clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_main <= '0;
        end else begin
            q_main <= next_val;
        end
    end

endmodule

// File: rtl/dsamp_compare.sv
// Bitwise comparison of main and shadow samples and the one-cycle
// flag and stall registers. The comparison is ignored in the cycle
// right after a correction, because the main register then holds the
// reloaded value rather than a fresh sample.
module dsamp_compare #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] q_main,
    input  logic [WIDTH-1:0] q_shd,
    output logic             correct,
    output logic             err_flag,
    output logic             stall
);
    import dsamp_pkg::*;

    logic [WIDTH-1:0] bit_diff;
    logic             mismatch;
    dsamp_event_s     ev_q;

    // Per-bit difference between the two samples.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign bit_diff[b] = q_main[b] ^ q_shd[b];
    end

    // Reduce the differences and mask the post-correction cycle.
    always_comb begin
        mismatch = |bit_diff;
        correct  = mismatch && !ev_q.stall;
    end

    // Register the event so flag and stall last one main cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q.flag  <= correct;
            ev_q.stall <= correct;
        end
    end

    assign err_flag = ev_q.flag;
    assign stall    = ev_q.stall;

endmodule

// File: rtl/dsamp_err_counter.sv
// Saturating event counter.
// Assumes inc is synchronous to clk.
module dsamp_err_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count each request, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dsamp_reg.sv
// Double-sampling timing error register, top level.
// Assumes every path into d is slower than the clk to clk_dly offset,
// and that upstream holds d for one cycle when stall is high.
module dsamp_reg #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             clk_dly,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             err_flag,
    output logic             stall,
    output logic [CNT_W-1:0] err_cnt
);

    logic [WIDTH-1:0] q_main;
    logic [WIDTH-1:0] q_shd;
    logic             correct;

    dsamp_shadow_stage #(.WIDTH(WIDTH)) i_shadow (
        .clk_dly (clk_dly),
        .rst_n   (rst_n),
        .d       (d),
        .q_shd   (q_shd)
    );

    dsamp_main_stage #(.WIDTH(WIDTH)) i_main (
        .clk         (clk),
        .rst_n       (rst_n),
        .d           (d),
        .load_shadow (correct),
        .shadow_q    (q_shd),
        .q_main      (q_main)
    );

    dsamp_compare #(.WIDTH(WIDTH)) i_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_main   (q_main),
        .q_shd    (q_shd),
        .correct  (correct),
        .err_flag (err_flag),
        .stall    (stall)
    );

    dsamp_err_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (correct),
        .cnt   (err_cnt)
    );

    assign q = q_main;

endmodule

// File: rtl/dsamp_reg_chk.sv
// Property checker for dsamp_reg, attached by bind.
module dsamp_reg_chk #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] q,
    input logic [WIDTH-1:0] q_shd,
    input logic             err_flag,
    input logic             stall,
    input logic [CNT_W-1:0] err_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_flag_from_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> ($past(q) != $past(q_shd)));

    assert_reload_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (q == $past(q_shd)));

    assert_single_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    assert_mask_after_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !err_flag);

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && $past(err_cnt) != CNT_MAX) |-> (err_cnt == $past(err_cnt) + 1'b1));

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag |-> $stable(err_cnt));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_cnt) == CNT_MAX) |-> (err_cnt == CNT_MAX));

endmodule

bind dsamp_reg dsamp_reg_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .q        (q),
    .q_shd    (q_shd),
    .err_flag (err_flag),
    .stall    (stall),
    .err_cnt  (err_cnt)
);

// File: tb/test_dsamp_reg.sv
// Directed bench for dsamp_reg. Main edges at multiples of the period,
// delayed edges DLY later. On-time data changes mid-cycle (after the
// delayed edge); late data changes 1 unit after a main edge.
module test_dsamp_reg;

    localparam int PERIOD = 10;
    localparam int HALF   = PERIOD / 2;
    localparam int DLY    = 3;
    localparam int WIDTH  = 8;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             clk;
    logic             clk_dly;
    logic             rst_n;
    logic [WIDTH-1:0] d;
    logic [WIDTH-1:0] q;
    logic             err_flag;
    logic             stall;
    logic [CNT_W-1:0] err_cnt;

    int checks;
    int fails;
    int exp_cnt;
    bit finished;

    dsamp_reg #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_dsamp_reg (
        .clk      (clk),
        .clk_dly  (clk_dly),
        .rst_n    (rst_n),
        .d        (d),
        .q        (q),
        .err_flag (err_flag),
        .stall    (stall),
        .err_cnt  (err_cnt)
    );

    initial begin
        clk = 1'b0;
        forever #(HALF) clk = ~clk;
    end

    initial begin
        clk_dly = 1'b0;
        #(DLY);
        forever #(HALF) clk_dly = ~clk_dly;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        d     = 8'h5A;
        repeat (3) @(posedge clk);
        #(HALF);
        check("R1", "q", q, 0);
        check("R1", "err_flag", err_flag, 0);
        check("R1", "stall", stall, 0);
        check("R1", "err_cnt", err_cnt, 0);
        rst_n = 1'b1;
    endtask

    // R2: on-time data passes without a flag.
    task automatic t_normal(input logic [WIDTH-1:0] v);
        @(posedge clk);
        #(HALF);
        d = v;
        @(posedge clk);
        #(HALF);
        check("R2", "q", q, v);
        check("R2", "err_flag", err_flag, 0);
        check("R2", "stall", stall, 0);
        check("R7", "err_cnt", err_cnt, exp_cnt);
    endtask

    // R3/R4/R5/R7: late data flagged, corrected, one stall.
    task automatic t_late(input string req, input logic [WIDTH-1:0] v);
        @(posedge clk);
        #1;
        d = v;
        @(posedge clk);
        #(HALF);
        if (exp_cnt < int'(CNT_MAX)) exp_cnt++;
        check(req, "err_flag", err_flag, 1);
        check("R4", "q corrected", q, v);
        check("R5", "stall", stall, 1);
        check("R7", "err_cnt", err_cnt, exp_cnt);
        @(posedge clk);
        #(HALF);
        check("R3", "err_flag cleared", err_flag, 0);
        check("R5", "stall cleared", stall, 0);
        check("R4", "q holds", q, v);
    endtask

    // R6: a disagreement inside the stall cycle is ignored.
    task automatic t_mask(input logic [WIDTH-1:0] v, input logic [WIDTH-1:0] w);
        @(posedge clk);
        #1;
        d = v;
        @(posedge clk);
        #1;
        d = w;
        if (exp_cnt < int'(CNT_MAX)) exp_cnt++;
        #(HALF - 1);
        check("R6", "stall in window", stall, 1);
        @(posedge clk);
        #(HALF);
        check("R6", "err_flag", err_flag, 0);
        check("R6", "stall", stall, 0);
        check("R6", "q", q, w);
        check("R6", "err_cnt", err_cnt, exp_cnt);
    endtask

    // R10: late data right after a stall is flagged again.
    task automatic t_back_to_back(input logic [WIDTH-1:0] v, input logic [WIDTH-1:0] w);
        t_late("R10", v);
        @(posedge clk);
        #(HALF);
        d = v;
        t_late("R10", w);
    endtask

    // R8: counter saturates.
    task automatic t_saturate();
        logic [WIDTH-1:0] v;
        v = q;
        for (int i = 0; i < 18; i++) begin
            v = v + 8'd3;
            t_late("R3", v);
        end
        check("R8", "err_cnt saturated", err_cnt, int'(CNT_MAX));
    endtask

    initial begin
        checks   = 0;
        fails    = 0;
        exp_cnt  = 0;
        finished = 0;
        rst_n    = 1'b0;
        d        = '0;
        t_reset();
        t_normal(8'h3C);
        t_normal(8'hC3);
        t_normal(8'h00);
        t_late("R3", 8'h81);
        t_late("R9", 8'h01);
        t_normal(8'h7E);
        t_mask(8'h12, 8'h34);
        t_back_to_back(8'hA5, 8'h5A);
        t_saturate();
        t_normal(8'hFF);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule